// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is the receiving end of a three-wire configuration link made of an active-low select, a serial clock and a data line. A host lowers the select, sends a 16-bit command word and then one or more data bytes, with the most significant bit first. The block stores each received byte in a shadow copy of an 8-bit register file. The values a device would act on are held in a second, active copy, and these are exposed on a flat output bus.

Shadow contents reach the active copy only when the host writes a dedicated commit address. Register 0 is the exception: a write to it lands in both copies at once. This lets its soft-reset bit act without a commit. Multi-byte writes stream downward, and the target address drops by one after every byte.

The three link inputs are brought into the system clock domain through synchronisers, and every edge is detected there. The system clock must therefore run at least four times faster than the serial clock.

Top module: `cfg_port_slave`

## Requirements
- R1: After reset every active register reads 0x00 and `softReset` is low.
- R2: A transaction starts when `csN` falls. Data is sampled on each rising edge of `sclk`, MSB first. The 16-bit command word has bit 15 as the direction flag (0 = write), bits 14:13 as the byte count minus one, and bits 6:0 as the start address; bits 12:7 are ignored. A written byte changes only the shadow copy, so the active value stays unchanged until a commit.
- R3: A write to address 0x5A copies every shadow register into the active copy. The commit register itself always reads 0x00.
- R4: With a byte count of n (field value n-1), the n data bytes go to the start address, then start-1, and so on downward.
- R5: A command with bit 15 set is a read. Its data bits are ignored and no register changes.
- R6: Raising `csN` ends the transaction. A partly received byte is discarded, while bytes completed earlier in the same transaction remain written. Clock edges while `csN` is high are ignored, and a new command is accepted only after `csN` falls again.
- R7: A write to address 0 updates active register 0 directly, with no commit needed.
- R8: When active register 0 takes a value with bit 5 set, `softReset` is high for exactly one system clock. At the next edge every shadow and active register, including register 0, returns to 0x00.
- R9: Writes to addresses at or above the register count (96) are dropped. Bytes sent after the count given in the command are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock, idles high |
| sdi | input | 1 | Serial data, changes after falling `sclk` |
| activeRegs | output | NUM_REGS*8 | Active registers; register k occupies bits 8k+7:8k |
| softReset | output | 1 | One-cycle pulse when the soft-reset bit is written |

## Verification
The path from a rising serial clock to a written byte runs through two synchroniser stages, one edge-detect stage, the registered strobe and the register bank. A written byte therefore reaches the outputs about five system clocks after the serial edge that completes it. A commit adds one more clock, and the clear after a soft reset adds another. The bench keeps `csN` high and waits twelve system clocks after every transaction before it samples any output, so all of these results have settled by then. It samples on falling clock edges. The one-cycle `softReset` pulse is caught by a monitor that counts high cycles at every rising edge.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  // address bits taken from the low end of the command word
  localparam int ADDR_W = 7;
  localparam int CMD_BITS = 16;
  localparam int BYTE_BITS = 8;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_CMD,
    PH_DATA,
    PH_DRAIN
  } phase_t;

  // one-cycle request from the control path to the register bank
  typedef struct packed {
    logic                 shadowWr;
    logic                 directWr;
    logic                 commit;
    logic [ADDR_W-1:0]    addr;
    logic [BYTE_BITS-1:0] data;
  } strobe_t;
endpackage

// File: rtl/cfg_port_sync.sv
module cfg_port_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[s] <= RESET_VAL;
        else       stage[s] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[s] <= RESET_VAL;
        else       stage[s] <= stage[s-1];
      end
    end
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/cfg_port_ctrl.sv
module cfg_port_ctrl
  import cfg_port_pkg::*;
#(
  parameter int NUM_REGS = 96,
  parameter int SYNC_STAGES = 2,
  parameter int UPDATE_ADDR = 90,
  parameter int CTRL_ADDR = 0
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    csN,
  input  logic    sclk,
  input  logic    sdi,
  output strobe_t stb
);
  localparam int CNT_W = $clog2(CMD_BITS);

  logic [2:0] syncOut;
  logic csS, sclkS, sdiS;
  logic csD, sclkD;
  logic sclkRise, csFall;

  cfg_port_sync #(
    .WIDTH(3),
    .STAGES(SYNC_STAGES),
    .RESET_VAL(3'b111)
  ) u_sync (
    .clk(clk),
    .rstN(rstN),
    .din({csN, sclk, sdi}),
    .dout(syncOut)
  );

  assign csS = syncOut[2];
  assign sclkS = syncOut[1];
  assign sdiS = syncOut[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csD <= 1'b1;
      sclkD <= 1'b1;
    end else begin
      csD <= csS;
      sclkD <= sclkS;
    end
  end

  assign sclkRise = sclkS & ~sclkD;
  assign csFall = ~csS & csD;

  phase_t phase;
  logic [CNT_W-1:0] bitCnt;
  logic [CMD_BITS-2:0] cmdSh;
  logic [BYTE_BITS-2:0] dataSh;
  logic [ADDR_W-1:0] addrQ;
  logic [1:0] bytesLeft;

  logic [BYTE_BITS-1:0] byteVal;
  logic inRange, isUpdate, isCtrl;

  always_comb begin
    byteVal = {dataSh, sdiS};
    inRange = int'(addrQ) < NUM_REGS;
    isUpdate = addrQ == ADDR_W'(UPDATE_ADDR);
    isCtrl = addrQ == ADDR_W'(CTRL_ADDR);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      bitCnt <= '0;
      cmdSh <= '0;
      dataSh <= '0;
      addrQ <= '0;
      bytesLeft <= '0;
      stb <= '0;
    end else begin
      stb <= '0;
      if (csS) begin
        // select high: drop any partial frame
        phase <= PH_IDLE;
        bitCnt <= '0;
      end else if (csFall) begin
        phase <= PH_CMD;
        bitCnt <= '0;
      end else if (sclkRise) begin
        unique case (phase)
          PH_CMD: begin
            cmdSh <= {cmdSh[CMD_BITS-3:0], sdiS};
            if (bitCnt == CNT_W'(CMD_BITS - 1)) begin
              bitCnt <= '0;
              addrQ <= {cmdSh[ADDR_W-2:0], sdiS};
              bytesLeft <= cmdSh[CMD_BITS-3:CMD_BITS-4];
              phase <= cmdSh[CMD_BITS-2] ? PH_DRAIN : PH_DATA;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
          PH_DATA: begin
            dataSh <= byteVal[BYTE_BITS-2:0];
            if (bitCnt == CNT_W'(BYTE_BITS - 1)) begin
              bitCnt <= '0;
              stb.commit <= isUpdate;
              stb.shadowWr <= inRange && !isUpdate;
              stb.directWr <= inRange && isCtrl;
              stb.addr <= addrQ;
              stb.data <= byteVal;
              addrQ <= addrQ - 1'b1;
              if (bytesLeft == 2'd0) phase <= PH_DRAIN;
              else bytesLeft <= bytesLeft - 1'b1;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/cfg_port_regs.sv
module cfg_port_regs
  import cfg_port_pkg::*;
#(
  parameter int NUM_REGS = 96,
  parameter int CTRL_ADDR = 0,
  parameter int SRST_BIT = 5
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  strobe_t                   stb,
  output logic [NUM_REGS*BYTE_BITS-1:0] activeFlat,
  output logic                      softReset
);
  logic [BYTE_BITS-1:0] shadowBank [NUM_REGS];
  logic [BYTE_BITS-1:0] activeBank [NUM_REGS];

  // the control bit lives in the active copy and clears itself one cycle later
  assign softReset = activeBank[CTRL_ADDR][SRST_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) begin
        shadowBank[i] <= '0;
        activeBank[i] <= '0;
      end
    end else if (softReset) begin
      for (int i = 0; i < NUM_REGS; i++) begin
        shadowBank[i] <= '0;
        activeBank[i] <= '0;
      end
    end else begin
      if (stb.shadowWr) shadowBank[stb.addr] <= stb.data;
      if (stb.directWr) activeBank[stb.addr] <= stb.data;
      if (stb.commit) begin
        for (int i = 0; i < NUM_REGS; i++) activeBank[i] <= shadowBank[i];
      end
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
    assign activeFlat[g*BYTE_BITS +: BYTE_BITS] = activeBank[g];
  end
endmodule

// File: rtl/cfg_port_slave.sv
module cfg_port_slave
  import cfg_port_pkg::*;
#(
  parameter int NUM_REGS = 96,
  parameter int SYNC_STAGES = 2,
  parameter int UPDATE_ADDR = 90,
  parameter int CTRL_ADDR = 0,
  parameter int SRST_BIT = 5
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  csN,
  input  logic                  sclk,
  input  logic                  sdi,
  output logic [NUM_REGS*8-1:0] activeRegs,
  output logic                  softReset
);
  strobe_t ctrlStb;

  cfg_port_ctrl #(
    .NUM_REGS(NUM_REGS),
    .SYNC_STAGES(SYNC_STAGES),
    .UPDATE_ADDR(UPDATE_ADDR),
    .CTRL_ADDR(CTRL_ADDR)
  ) u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .csN(csN),
    .sclk(sclk),
    .sdi(sdi),
    .stb(ctrlStb)
  );

  cfg_port_regs #(
    .NUM_REGS(NUM_REGS),
    .CTRL_ADDR(CTRL_ADDR),
    .SRST_BIT(SRST_BIT)
  ) u_regs (
    .clk(clk),
    .rstN(rstN),
    .stb(ctrlStb),
    .activeFlat(activeRegs),
    .softReset(softReset)
  );
endmodule

// File: rtl/cfg_port_slave_chk.sv
module cfg_port_slave_chk #(
  parameter int NUM_REGS = 96,
  parameter int UPDATE_ADDR = 90,
  parameter int CTRL_ADDR = 0
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  csN,
  input logic [NUM_REGS*8-1:0] activeRegs,
  input logic                  softReset,
  input logic                  stbDirect,
  input logic [7:0]            stbData
);
  logic [3:0] idleCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) idleCnt <= '0;
    else if (!csN) idleCnt <= '0;
    else if (idleCnt != 4'hF) idleCnt <= idleCnt + 1'b1;
  end

  assert_softreset_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    softReset |=> !softReset);

  assert_softreset_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    softReset |=> (activeRegs == '0));

  assert_update_reads_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    activeRegs[UPDATE_ADDR*8 +: 8] == 8'h00);

  assert_direct_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    stbDirect |=> (activeRegs[CTRL_ADDR*8 +: 8] == $past(stbData)));

  assert_idle_stable_R6: assert property (@(posedge clk) disable iff (!rstN)
    (idleCnt >= 4'd12) |-> $stable(activeRegs));
endmodule

bind cfg_port_slave cfg_port_slave_chk #(
  .NUM_REGS(NUM_REGS),
  .UPDATE_ADDR(UPDATE_ADDR),
  .CTRL_ADDR(CTRL_ADDR)
) u_chk (
  .clk(clk),
  .rstN(rstN),
  .csN(csN),
  .activeRegs(activeRegs),
  .softReset(softReset),
  .stbDirect(ctrlStb.directWr),
  .stbData(ctrlStb.data)
);

// File: tb/cfg_port_slave_test.sv
`timescale 1ns/1ps
module cfg_port_slave_test;
  localparam int NUM_REGS = 96;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic sclk = 1'b1;
  logic sdi = 1'b1;
  logic [NUM_REGS*8-1:0] activeRegs;
  logic softReset;

  int checks = 0;
  int errors = 0;
  int pulseCnt = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  cfg_port_slave uut (
    .clk(clk),
    .rstN(rstN),
    .csN(csN),
    .sclk(sclk),
    .sdi(sdi),
    .activeRegs(activeRegs),
    .softReset(softReset)
  );

  always @(posedge clk) if (softReset) pulseCnt <= pulseCnt + 1;

  function automatic logic [7:0] regAt(int a);
    return activeRegs[a*8 +: 8];
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitClk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBit(logic b);
    sclk = 1'b0;
    sdi = b;
    waitClk(HALF);
    sclk = 1'b1;
    waitClk(HALF);
  endtask

  task automatic sendWord(logic [15:0] w, int nBits);
    for (int i = 15; i > 15 - nBits; i--) sendBit(w[i]);
  endtask

  // full frame: command then nb bytes, select raised at end
  task automatic frame(logic rd, logic [1:0] cnt, logic [6:0] addr, int nb,
                       logic [7:0] d0, logic [7:0] d1, logic [7:0] d2);
    logic [7:0] bytes [3];
    bytes[0] = d0; bytes[1] = d1; bytes[2] = d2;
    csN = 1'b0;
    waitClk(HALF);
    sendWord({rd, cnt, 6'b0, addr}, 16);
    for (int k = 0; k < nb; k++) sendWord({bytes[k], 8'h00}, 8);
    waitClk(HALF);
    csN = 1'b1;
    waitClk(12);
  endtask

  task automatic commitAll();
    frame(1'b0, 2'b00, 7'h5A, 1, 8'hFF, 8'h00, 8'h00);
  endtask

  task automatic testReset();
    check("R1 softReset", softReset, 0);
    check("R1 all regs", (activeRegs == '0), 1);
  endtask

  task automatic testSingle();
    frame(1'b0, 2'b00, 7'h45, 1, 8'hC1, 8'h00, 8'h00);
    check("R2 shadow only", regAt(8'h45), 8'h00);
    commitAll();
    check("R2 msb-first value", regAt(8'h45), 8'hC1);
    check("R3 commit reg zero", regAt(8'h5A), 8'h00);
  endtask

  task automatic testStream();
    frame(1'b0, 2'b10, 7'h20, 3, 8'h11, 8'h22, 8'h33);
    check("R4 before commit", regAt(8'h20), 8'h00);
    commitAll();
    check("R4 first", regAt(8'h20), 8'h11);
    check("R4 second", regAt(8'h1F), 8'h22);
    check("R4 third", regAt(8'h1E), 8'h33);
    check("R4 above untouched", regAt(8'h21), 8'h00);
  endtask

  task automatic testRead();
    frame(1'b1, 2'b00, 7'h45, 1, 8'h3C, 8'h00, 8'h00);
    commitAll();
    check("R5 read ignored", regAt(8'h45), 8'hC1);
  endtask

  task automatic testAbort();
    csN = 1'b0;
    waitClk(HALF);
    sendWord({1'b0, 2'b01, 6'b0, 7'h30}, 16);
    sendWord({8'h77, 8'h00}, 8);
    sendWord({8'h88, 8'h00}, 3);
    waitClk(HALF);
    csN = 1'b1;
    waitClk(12);
    // clocks with select high must do nothing
    sendWord({1'b0, 2'b00, 6'b0, 7'h31}, 16);
    sendWord({8'h99, 8'h00}, 8);
    waitClk(12);
    commitAll();
    check("R6 completed byte kept", regAt(8'h30), 8'h77);
    check("R6 partial byte dropped", regAt(8'h2F), 8'h00);
    check("R6 clocks while high ignored", regAt(8'h31), 8'h00);
  endtask

  task automatic testDirect();
    frame(1'b0, 2'b00, 7'h00, 1, 8'h10, 8'h00, 8'h00);
    check("R7 reg0 immediate", regAt(0), 8'h10);
    check("R7 no soft reset", pulseCnt, 0);
  endtask

  task automatic testRange();
    frame(1'b0, 2'b00, 7'h60, 1, 8'hEE, 8'h00, 8'h00);
    frame(1'b0, 2'b00, 7'h10, 2, 8'h44, 8'h55, 8'h00);
    commitAll();
    check("R9 out of range no alias", regAt(8'h20), 8'h11);
    check("R9 out of range no alias low", regAt(8'h00), 8'h10);
    check("R9 counted byte", regAt(8'h10), 8'h44);
    check("R9 excess byte dropped", regAt(8'h0F), 8'h00);
  endtask

  task automatic testSoftReset();
    frame(1'b0, 2'b00, 7'h50, 1, 8'h6B, 8'h00, 8'h00);
    frame(1'b0, 2'b00, 7'h00, 1, 8'h30, 8'h00, 8'h00);
    check("R8 pulse count", pulseCnt, 1);
    check("R8 softReset low", softReset, 0);
    check("R8 active cleared", (activeRegs == '0), 1);
    commitAll();
    check("R8 shadow cleared", regAt(8'h50), 8'h00);
    check("R8 shadow cleared old", regAt(8'h45), 8'h00);
  endtask

  initial begin
    waitClk(5);
    rstN = 1'b1;
    waitClk(5);
    testReset();
    testSingle();
    testStream();
    testRead();
    testAbort();
    testDirect();
    testRange();
    testSoftReset();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule